// File: doc/BRIEF.md
# UART Receive Line Status Unit with Error-Tagged FIFO

This block is the receive half of a serial port together with its line status register. An oversampled receiver takes the incoming line and builds characters of 5 to 8 data bits, with an optional parity bit and one stop bit. Each finished character goes into a 16-entry receive queue. Every entry carries three error tags: parity, framing and break. The CPU sees a status byte. Its error bits describe only the character at the head of the queue, so an error is reported when the software reaches the character that caused it and not before.

A break is a line held low for a whole frame. It produces exactly one all-zero entry, and the receiver then waits for the line to go high again. The transmit side is reduced to an occupancy count of the holding stage. That count drives the holding-empty flag and a holding-empty interrupt request. Baud generation sits outside the block and supplies a sample tick at 16 times the bit rate.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status byte `lsr_out` reads 0x20: holding-empty (bit 5) is 1, and data-ready, overrun and the three error bits are 0. Bits 7:6 always read 0 and `rx_data` reads 0.
- R2: A character starts at a falling edge of the synchronised line. Each bit is decided by a 2-of-3 vote over oversample ticks 7, 8 and 9 of that bit. Data arrives LSB first, with 5 + `cfg_len` data bits, and is zero-extended to 8 bits. The character is written into the queue at the tick-8 decision point of the stop bit, 11 + 16*S clock edges after the line falls, where S = 1 + data bits + parity bit. This timing holds when a tick comes every clock, counting two synchroniser stages. Data-ready (bit 0) is 1 while the queue is not empty.
- R3: A start bit whose vote is high is discarded as a glitch and queues nothing.
- R4: With `cfg_par_en` = 1 the parity bit makes the total count of ones even (`cfg_par_odd` = 0) or odd (`cfg_par_odd` = 1). A mismatch sets the parity tag, which appears as bit 2. With parity disabled the parity tag is never set.
- R5: A stop bit that votes 0 sets the framing tag, which appears as bit 3, unless the frame is a break.
- R6: If the start, data, parity and stop bits all vote 0, one 0x00 entry carrying only the break tag is queued, and this tag appears as bit 4. No further character is framed until the line has returned high.
- R7: Bits 4:2 are built only from the tags of the head entry. When an entry becomes the head at clock edge E, its tags are OR-ed into the status bits at edge E+1. Tags of entries behind the head are not visible.
- R8: Bits 4:2 and overrun are sticky. A status read (`lsr_rd`) clears them, except that a head tag or overrun arriving in the same cycle still sets its bit.
- R9: A character that completes while the queue is full is discarded and sets overrun (bit 1). The queue holds 16 entries when `cfg_fifo_en` = 1 and 1 entry otherwise.
- R10: Holding-empty (bit 5) is 1 while the transmit holding count is 0. `thr_wr` adds a byte if there is room (16 in FIFO mode, 1 otherwise). `tsr_load` removes one if the count is non-zero. A status read leaves the flag unchanged.
- R11: `thre_irq` equals `thre_irq_en` AND holding-empty.
- R12: `rx_data` shows the head entry's byte, or 0 when the queue is empty. `rx_rd` removes the head, and has no effect on an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_fifo_en | input | 1 | 1: 16-deep queues, 0: single holding stage |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_rd | input | 1 | Pop the receive queue head |
| rx_data | output | 8 | Head entry data byte |
| lsr_rd | input | 1 | Status read strobe, clears sticky bits |
| lsr_out | output | 8 | Line status byte |
| thr_wr | input | 1 | CPU write into the transmit holding stage |
| tsr_load | input | 1 | Shift register takes a byte from the holding stage |
| thre_irq_en | input | 1 | Holding-empty interrupt enable |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
On every cycle the assertions check five rules. Overrun is set on a dropped character and cleared on a plain read. The error bits rise only one clock after a new head appears. The parity tag stays silent while parity is off, and queue and holding counts stay in range. Holding-empty survives a status read, and a holding write always clears it. Only the bench's scenarios can show the rest. These are the actual bit framing for each length and parity mode, the rejection of a glitch, and the single zero entry from a long break. They also cover an error that stays hidden behind a clean head until that head is popped, and the choice between 16-entry and single-stage depth.

// File: rtl/uls_pkg.sv
package uls_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  typedef struct packed {
    rx_tag_t    tag;
    logic [7:0] data;
  } rx_entry_t;

  // 2-of-3 vote of the mid-bit samples
  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // bits arrive into the MSB end; shift the character down to bit 0
  function automatic logic [7:0] align_char(logic [7:0] sh, logic [1:0] len_code);
    return sh >> (2'd3 - len_code);
  endfunction

  // index of the final data bit for a length code (5 bits -> 4)
  function automatic logic [2:0] last_index(logic [1:0] len_code);
    return 3'd4 + {1'b0, len_code};
  endfunction

  function automatic logic [7:0] lsr_pack(logic thre, logic [2:0] errs,
                                          logic oe, logic dr);
    return {2'b00, thre, errs, oe, dr};
  endfunction

endpackage

// File: rtl/uls_line_rx.sv
module uls_line_rx
  import uls_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OSR         = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] len_code,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push,
  output rx_entry_t push_entry
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] PRE1 = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] PRE2 = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
  } rx_state_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [1:0]             samp;
  logic [7:0]             shreg;
  logic [2:0]             bit_idx;
  logic                   any_one, par_acc, par_bad;
  logic                   bit_now, is_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign bit_now = vote3(samp[1], samp[0], rx_s);
  assign is_brk  = !bit_now && !any_one;
  assign push    = tick && (state == S_STOP) && (cnt == MID);

  always_comb begin
    if (is_brk) begin
      push_entry.data = 8'h00;
      push_entry.tag  = '{brk: 1'b1, frm: 1'b0, par: 1'b0};
    end else begin
      push_entry.data = align_char(shreg, len_code);
      push_entry.tag  = '{brk: 1'b0, frm: !bit_now, par: par_bad};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      samp    <= 2'b11;
      shreg   <= '0;
      bit_idx <= '0;
      any_one <= 1'b0;
      par_acc <= 1'b0;
      par_bad <= 1'b0;
    end else if (tick) begin
      unique case (state)
        S_IDLE: if (!rx_s) begin
          state   <= S_START;
          cnt     <= '0;
          shreg   <= '0;
          bit_idx <= '0;
          any_one <= 1'b0;
          par_acc <= 1'b0;
          par_bad <= 1'b0;
        end
        S_BRKW: if (rx_s) state <= S_IDLE;
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == PRE1 || cnt == PRE2) samp <= {samp[0], rx_s};
          case (state)
            S_START: begin
              if (cnt == MID && bit_now) state <= S_IDLE;
              else if (cnt == LAST)     state <= S_DATA;
            end
            S_DATA: begin
              if (cnt == MID) begin
                shreg   <= {bit_now, shreg[7:1]};
                any_one <= any_one | bit_now;
                par_acc <= par_acc ^ bit_now;
              end
              if (cnt == LAST) begin
                if (bit_idx == last_index(len_code)) state <= par_en ? S_PAR : S_STOP;
                else bit_idx <= bit_idx + 1'b1;
              end
            end
            S_PAR: begin
              if (cnt == MID) begin
                any_one <= any_one | bit_now;
                par_bad <= bit_now != (par_acc ^ par_odd);
              end
              if (cnt == LAST) state <= S_STOP;
            end
            S_STOP: if (cnt == MID) state <= is_brk ? S_BRKW : S_IDLE;
            default: ;
          endcase
        end
      endcase
    end
  end

  // R2: a stop decision is a single tick; two characters never complete back to back
  a_r2_push_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R4: parity tag only exists while parity checking is on
  a_r4_par_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !par_en) |-> !push_entry.tag.par);

endmodule

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_one,
  input  logic                     push,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     pop,
  output logic [WIDTH-1:0]         head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH)-1:0] rd_ptr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PMAX) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = cap_one ? !empty : (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R9: occupancy never exceeds the storage
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R12: a pop on an empty queue leaves it empty
  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/uls_tx_hold.sv
module uls_tx_hold #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_one,
  input  logic wr,
  input  logic load,
  output logic thre
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          room, take;

  assign room = cap_one ? (cnt == '0) : (cnt != CW'(DEPTH));
  assign take = load && (cnt != '0);
  assign thre = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CW'(wr && room) - CW'(take);
  end

  // R10: an accepted write always leaves a byte waiting
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && room) |=> !thre);

  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int RX_DEPTH    = 16,
  parameter int TX_DEPTH    = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic       cfg_fifo_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  input  logic       lsr_rd,
  output logic [7:0] lsr_out,
  input  logic       thr_wr,
  input  logic       tsr_load,
  input  logic       thre_irq_en,
  output logic       thre_irq
);
  localparam int EW = $bits(rx_entry_t);
  localparam int PW = $clog2(RX_DEPTH);

  logic            rx_push, rx_empty, rx_full, thre;
  rx_entry_t       push_entry, head_e;
  logic [EW-1:0]   head_raw;
  logic [PW-1:0]   rd_ptr;
  logic [PW:0]     head_key, head_key_q;
  logic            head_new, ovf_evt;
  logic [2:0]      err_q;
  logic            oe_q;

  uls_line_rx #(.SYNC_STAGES(SYNC_STAGES), .OSR(OSR)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rxd(rxd),
    .len_code(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .push(rx_push), .push_entry(push_entry)
  );

  uls_rx_fifo #(.WIDTH(EW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap_one(!cfg_fifo_en),
    .push(rx_push), .wdata(push_entry), .pop(rx_rd),
    .head(head_raw), .empty(rx_empty), .full(rx_full), .rd_ptr(rd_ptr)
  );

  uls_tx_hold #(.DEPTH(TX_DEPTH)) u_txh (
    .clk(clk), .rst_n(rst_n), .cap_one(!cfg_fifo_en),
    .wr(thr_wr), .load(tsr_load), .thre(thre)
  );

  assign head_e   = rx_entry_t'(head_raw);
  assign head_key = {rx_empty, rd_ptr};
  assign head_new = !rx_empty && (head_key != head_key_q);
  assign ovf_evt  = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_key_q <= {1'b1, {PW{1'b0}}};
      err_q      <= '0;
      oe_q       <= 1'b0;
    end else begin
      head_key_q <= head_key;
      err_q      <= (lsr_rd ? 3'b000 : err_q) | (head_new ? head_e.tag : 3'b000);
      oe_q       <= (lsr_rd ? 1'b0 : oe_q) | ovf_evt;
    end
  end

  assign rx_data  = head_e.data;
  assign lsr_out  = lsr_pack(thre, err_q, oe_q, !rx_empty);
  assign thre_irq = thre_irq_en && thre;

  // R9: a dropped character shows as overrun
  a_r9_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> lsr_out[1]);

  // R8: a read with no new overrun clears the bit
  a_r8_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovf_evt) |=> !lsr_out[1]);

  // R7: error bits rise only in the cycle after a new head appears
  a_r7_rise_on_head: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lsr_out[4:2] & ~$past(lsr_out[4:2]))) |-> $past(head_new));

  // R10: a status read alone does not move holding-empty
  a_r10_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !thr_wr && !tsr_load) |=> $stable(lsr_out[5]));

endmodule

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       cfg_fifo_en = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rx_rd = 1'b0, lsr_rd = 1'b0, thr_wr = 1'b0, tsr_load = 1'b0;
  logic       thre_irq_en = 1'b0;
  logic [7:0] rx_data, lsr_out;
  logic       thre_irq;

  uart_line_status u_uart_line_status (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_fifo_en(cfg_fifo_en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .rx_rd(rx_rd), .rx_data(rx_data),
    .lsr_rd(lsr_rd), .lsr_out(lsr_out), .thr_wr(thr_wr), .tsr_load(tsr_load),
    .thre_irq_en(thre_irq_en), .thre_irq(thre_irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int id; int data; int tags; } ent_t;
  ent_t mq[$];
  ent_t sq[$];
  int   sedge[$];
  int   cyc = 0, next_id = 0;
  int   m_err = 0, m_oe = 0, prev_id = -1, txc = 0;
  int   m_pre, m_hid, m_cap, m_ovf, m_pushing;
  ent_t m_in;

  task automatic schedule(int edge_no, int data, int tags);
    ent_t e;
    e.id = next_id; e.data = data; e.tags = tags;
    next_id++;
    sq.push_back(e);
    sedge.push_back(edge_no);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); m_err = 0; m_oe = 0; prev_id = -1; txc = 0;
    end else begin
      m_pre = mq.size();
      m_hid = (m_pre > 0) ? mq[0].id : -1;
      m_err = lsr_rd ? 0 : m_err;
      if (m_pre > 0 && m_hid != prev_id) m_err = m_err | mq[0].tags;
      prev_id = m_hid;
      m_cap = cfg_fifo_en ? 16 : 1;
      m_ovf = 0; m_pushing = 0;
      if (sedge.size() > 0 && sedge[0] == cyc) begin
        m_in = sq.pop_front();
        void'(sedge.pop_front());
        if (m_pre >= m_cap) m_ovf = 1; else m_pushing = 1;
      end
      if (rx_rd && m_pre > 0) void'(mq.pop_front());
      if (m_pushing) mq.push_back(m_in);
      m_oe = (lsr_rd ? 0 : m_oe) | m_ovf;
      if (tsr_load && txc > 0) txc = txc - 1 + ((thr_wr && (cfg_fifo_en ? txc < 16 : txc == 0)) ? 1 : 0);
      else if (thr_wr && (cfg_fifo_en ? txc < 16 : txc == 0)) txc = txc + 1;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R2 data-ready", lsr_out[0], mq.size() > 0);
      check("R9 overrun", lsr_out[1], m_oe);
      check("R4 parity flag", lsr_out[2], m_err & 1);
      check("R5 framing flag", lsr_out[3], (m_err >> 1) & 1);
      check("R6 break flag", lsr_out[4], (m_err >> 2) & 1);
      check("R10 holding-empty", lsr_out[5], txc == 0);
      check("R1 upper bits", lsr_out[7:6], 0);
      check("R12 head data", rx_data, (mq.size() > 0) ? mq[0].data : 0);
      check("R11 interrupt", thre_irq, thre_irq_en && (txc == 0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(bit v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(int data, int nb, bit pen, bit podd, bit flip, bit stop_v);
    int s, mask, k, tags;
    bit p;
    s = 1 + nb + (pen ? 1 : 0);
    mask = (1 << nb) - 1;
    p = (^(data & mask)) ^ podd ^ flip;
    tags = ((pen && flip) ? 1 : 0) | (stop_v ? 0 : 2);
    @(negedge clk);
    k = cyc + 1;
    schedule(k + 11 + 16 * s, data & mask, tags);
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) hold(data[i], 16);
    if (pen) hold(p, 16);
    hold(stop_v, 16);
    hold(1'b1, 24);
  endtask

  task automatic send_break(int nb, bit pen, int frames_low);
    int s, k;
    s = 1 + nb + (pen ? 1 : 0);
    @(negedge clk);
    k = cyc + 1;
    schedule(k + 11 + 16 * s, 0, 4);
    hold(1'b0, 16 * (s + 1) * frames_low);
    hold(1'b1, 40);
  endtask

  task automatic strobe(int which);
    @(negedge clk);
    case (which)
      0: rx_rd = 1'b1;
      1: lsr_rd = 1'b1;
      2: thr_wr = 1'b1;
      default: tsr_load = 1'b1;
    endcase
    @(negedge clk);
    rx_rd = 1'b0; lsr_rd = 1'b0; thr_wr = 1'b0; tsr_load = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", lsr_out, 8'h20);
    check("R1 reset data", rx_data, 0);
    thre_irq_en = 1'b1;
    @(negedge clk);
    check("R11 irq when empty", thre_irq, 1);

    // 8 data bits, no parity
    send_frame(8'hA5, 8, 0, 0, 0, 1);
    check("R2 eight-bit char", rx_data, 8'hA5);
    check("R2 data-ready", lsr_out[0], 1);
    strobe(0); settle();
    check("R12 popped", lsr_out[0], 0);

    // 5 data bits
    cfg_len = 2'd0;
    send_frame(8'h13, 5, 0, 0, 0, 1);
    check("R2 five-bit char", rx_data, 8'h13);
    strobe(0);

    // 7 bits even parity, correct
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(8'h5A, 7, 1, 0, 0, 1);
    settle();
    check("R4 good even parity", lsr_out[2], 0);
    check("R4 seven-bit char", rx_data, 8'h5A);
    strobe(0);

    // 6 bits odd parity, corrupted
    cfg_len = 2'd1; cfg_par_odd = 1'b1;
    send_frame(8'h2B, 6, 1, 1, 1, 1);
    settle();
    check("R4 bad odd parity", lsr_out[2], 1);
    strobe(1); settle();
    check("R8 parity cleared by read", lsr_out[2], 0);
    strobe(0);

    // framing error
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    send_frame(8'h3C, 8, 0, 0, 0, 0);
    settle();
    check("R5 framing error", lsr_out[3], 1);
    strobe(0); settle();
    check("R8 framing sticky after pop", lsr_out[3], 1);
    strobe(1); settle();
    check("R8 framing cleared by read", lsr_out[3], 0);

    // error hidden behind a clean head
    send_frame(8'h11, 8, 0, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 0, 0);
    settle();
    check("R7 error behind head hidden", lsr_out[3], 0);
    strobe(0); settle();
    check("R7 error shown at head", lsr_out[3], 1);
    check("R7 head data", rx_data, 8'h22);
    strobe(0); strobe(1); settle();

    // long break then a normal character
    send_break(8, 0, 5);
    send_frame(8'h66, 8, 0, 0, 0, 1);
    settle();
    check("R6 break entry zero", rx_data, 0);
    check("R6 break flag", lsr_out[4], 1);
    strobe(0); settle();
    check("R6 single zero entry", rx_data, 8'h66);
    strobe(0); strobe(1); settle();
    check("R6 break flag cleared", lsr_out[4], 0);

    // glitch on the line
    hold(1'b0, 4);
    hold(1'b1, 200);
    check("R3 glitch ignored", lsr_out[0], 0);

    // overrun with 16-entry queue
    for (int i = 0; i < 17; i++) send_frame(8'h40 + i, 8, 0, 0, 0, 1);
    settle();
    check("R9 overrun after 17 chars", lsr_out[1], 1);
    for (int i = 0; i < 16; i++) begin
      check("R12 queue order", rx_data, 8'h40 + i);
      strobe(0);
    end
    settle();
    check("R9 seventeenth discarded", lsr_out[0], 0);
    strobe(0); settle();
    check("R12 empty pop ignored", rx_data, 0);
    strobe(1); settle();
    check("R8 overrun cleared", lsr_out[1], 0);

    // single-stage mode
    cfg_fifo_en = 1'b0;
    send_frame(8'h71, 8, 0, 0, 0, 1);
    send_frame(8'h72, 8, 0, 0, 0, 1);
    settle();
    check("R9 single stage overrun", lsr_out[1], 1);
    check("R9 first kept", rx_data, 8'h71);
    strobe(0); strobe(1); settle();

    // transmit holding, FIFO mode
    cfg_fifo_en = 1'b1;
    repeat (3) strobe(2);
    settle();
    check("R10 written", lsr_out[5], 0);
    check("R11 irq low", thre_irq, 0);
    strobe(1); settle();
    check("R10 read ignored", lsr_out[5], 0);
    strobe(3); strobe(3); settle();
    check("R10 one left", lsr_out[5], 0);
    strobe(3); settle();
    check("R10 drained", lsr_out[5], 1);
    check("R11 irq back", thre_irq, 1);

    // transmit holding, single stage
    cfg_fifo_en = 1'b0;
    strobe(2); strobe(2); settle();
    check("R10 single stage full", lsr_out[5], 0);
    strobe(3); settle();
    check("R10 single stage empty", lsr_out[5], 1);

    settle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule